// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block tracks the power-management state of a processor core. It has four states: Normal, HALT, Stop-Grant and Grant-Snoop. A halt request parks the core in HALT. An active-low stop-clock request from the platform stops the clocks in Stop-Grant. A bus snoop that arrives while clocks are stopped moves the controller to Grant-Snoop long enough to service it. When the stop-clock request is withdrawn, the controller returns to whichever of Normal or HALT it left.

Five asynchronous event lines (a management interrupt, an init request, a bus init, and two local interrupts) are synchronised and latched as pending flags. Those flags reach the core only while its clocks run (Normal or HALT) and are held while the clocks are stopped. Each flag stays pending until its own acknowledge bit clears it.

A functional reset input re-initialises the block's internal state. If it arrives while the clocks are stopped, the controller does not leave the stopped state; later it wakes into Normal.

Top module: `lpstate_ctrl`

## Requirements
- R1: After power-on reset (`rstN` low), `pstate` is Normal (00), `clkStopEn` is 0 and `evtPend` is all zeros. State codes: 00 Normal, 01 HALT, 10 Stop-Grant, 11 Grant-Snoop.
- R2: In Normal, with `haltReq` high, no active stop request and no `cpuReset`, `pstate` is HALT after the next rising edge.
- R3: `stopClkN` passes through a two-flop synchroniser. A low level applied before rising edge k moves Normal or HALT to Stop-Grant at edge k+2, and not earlier. An active stop request takes priority over halt, wake and reset in Normal and HALT.
- R4: Once a synchronised high `stopClkN` is seen in Stop-Grant (same two-edge latency), the controller returns to HALT if Stop-Grant was entered from HALT, and to Normal otherwise.
- R5: `snoopStb` in Stop-Grant moves to Grant-Snoop on the next edge. `snoopDone` in Grant-Snoop returns to Stop-Grant on the next edge. `snoopStb` has no effect in Normal.
- R6: `clkStopEn` is 1 exactly when `pstate` is Stop-Grant; it is 0 in Grant-Snoop.
- R7: Each `evtIn` bit (0 SMI, 1 INIT, 2 BINIT, 3 LINT0, 4 LINT1) is synchronised by two flops and latched on the following edge. The latch holds its value in Stop-Grant and Grant-Snoop. `evtPend` shows the latched bits only in Normal or HALT and is 0 otherwise.
- R8: An `evtAck` bit clears only its own latched flag, and only in Normal or HALT; in Stop-Grant it has no effect. A newly latched event wins over an acknowledge of the same bit in the same cycle. Several flags can be pending at once.
- R9: In HALT with no active stop request, any latched event moves the controller to Normal on the next edge.
- R10: `cpuReset` clears all latched events. In Normal or HALT it forces Normal. In Stop-Grant or Grant-Snoop it leaves the state unchanged but makes the later wake-up target Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| stopClkN | input | 1 | Asynchronous stop-clock request, active low |
| haltReq | input | 1 | Halt request from the core |
| snoopStb | input | 1 | Bus snoop observed |
| snoopDone | input | 1 | Snoop service finished |
| cpuReset | input | 1 | Functional reset, synchronous |
| evtIn | input | 5 | Asynchronous event lines |
| evtAck | input | 5 | Per-flag acknowledge |
| pstate | output | 2 | Current power state |
| clkStopEn | output | 1 | Clock-stop enable |
| evtPend | output | 5 | Pending events presented to the core |

## Verification
The hardest case to reach is a functional reset that lands inside Stop-Grant after an event has been latched there, followed by the stop request being withdrawn. The controller must then wake into Normal rather than HALT, with no pending flag. The stimulus halts the core, stops its clocks, pulses an event, pulses `cpuReset`, and only then releases `stopClkN`. A second hard case is an acknowledge that coincides with a fresh event on the same bit; the bench times the acknowledge to the cycle in which the synchronised event reaches the latch.

// File: rtl/lpstate_pkg.sv
package lpstate_pkg;

  typedef enum logic [1:0] {
    PS_NORMAL    = 2'd0,
    PS_HALT      = 2'd1,
    PS_STOPGRANT = 2'd2,
    PS_SNOOP     = 2'd3
  } pstate_t;

  // Strobes from control to the event datapath
  typedef struct packed {
    logic present;  // clocks running: flags visible and ackable
    logic clear;    // functional reset: drop every latched flag
  } evtStb_t;

endpackage

// File: rtl/lpstate_sync.sv
module lpstate_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= RST_VAL;
      else       stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/lpstate_ctl.sv
module lpstate_ctl
  import lpstate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    stopClkN,
  input  logic    haltReq,
  input  logic    snoopStb,
  input  logic    snoopDone,
  input  logic    cpuReset,
  input  logic    anyPend,
  output pstate_t state,
  output evtStb_t stb,
  output logic    clkStopEn
);

  logic    stopClkNSync;
  logic    stopAct;
  logic    retHalt, retHaltNext;
  pstate_t stateNext;

  lpstate_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stopSync (
    .clk  (clk),
    .rstN (rstN),
    .d    (stopClkN),
    .q    (stopClkNSync)
  );

  assign stopAct = !stopClkNSync;

  always_comb begin
    stateNext   = state;
    retHaltNext = retHalt;
    case (state)
      PS_NORMAL: begin
        if (stopAct) begin
          stateNext   = PS_STOPGRANT;
          retHaltNext = 1'b0;
        end else if (!cpuReset && haltReq) begin
          stateNext = PS_HALT;
        end
      end
      PS_HALT: begin
        if (stopAct) begin
          stateNext   = PS_STOPGRANT;
          retHaltNext = !cpuReset;
        end else if (cpuReset || anyPend) begin
          stateNext = PS_NORMAL;
        end
      end
      PS_STOPGRANT: begin
        if (cpuReset) retHaltNext = 1'b0;
        if (!stopAct) begin
          stateNext = (retHalt && !cpuReset) ? PS_HALT : PS_NORMAL;
        end else if (snoopStb) begin
          stateNext = PS_SNOOP;
        end
      end
      PS_SNOOP: begin
        if (cpuReset) retHaltNext = 1'b0;
        if (snoopDone) stateNext = PS_STOPGRANT;
      end
      default: stateNext = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PS_NORMAL;
      retHalt <= 1'b0;
    end else begin
      state   <= stateNext;
      retHalt <= retHaltNext;
    end
  end

  assign stb.present = (state == PS_NORMAL) || (state == PS_HALT);
  assign stb.clear   = cpuReset;
  assign clkStopEn   = (state == PS_STOPGRANT);

  a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_NORMAL && haltReq && !stopAct && !cpuReset) |=> state == PS_HALT);

  a_r4_back_to_halt: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_STOPGRANT && !stopAct && retHalt && !cpuReset) |=> state == PS_HALT);

  a_r5_snoop_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_SNOOP && snoopDone) |=> state == PS_STOPGRANT);

  a_r10_sg_kept: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_STOPGRANT && cpuReset && stopAct && !snoopStb) |=> state == PS_STOPGRANT);

  a_r6_stop_hides_events: assert property (@(posedge clk) disable iff (!rstN)
    clkStopEn |-> !stb.present);

endmodule

// File: rtl/lpstate_evt.sv
module lpstate_evt
  import lpstate_pkg::*;
#(
  parameter int NUM_EVT = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [NUM_EVT-1:0] evtAck,
  input  evtStb_t            stb,
  output logic [NUM_EVT-1:0] evtPend,
  output logic               anyPend
);

  logic [NUM_EVT-1:0] evtSync;
  logic [NUM_EVT-1:0] latched;

  lpstate_sync #(.W(NUM_EVT), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_evtSync (
    .clk  (clk),
    .rstN (rstN),
    .d    (evtIn),
    .q    (evtSync)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    logic flag;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          flag <= 1'b0;
      else if (stb.clear)                 flag <= 1'b0;
      else if (evtSync[i])                flag <= 1'b1;
      else if (stb.present && evtAck[i])  flag <= 1'b0;
    end
    assign latched[i] = flag;
  end

  assign evtPend = latched & {NUM_EVT{stb.present}};
  assign anyPend = |latched;

  a_r7_held_while_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.present && !stb.clear) |=> ((latched & $past(latched)) == $past(latched)));

  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> latched == '0);

endmodule

// File: rtl/lpstate_ctrl.sv
module lpstate_ctrl
  import lpstate_pkg::*;
#(
  parameter int NUM_EVT = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stopClkN,
  input  logic               haltReq,
  input  logic               snoopStb,
  input  logic               snoopDone,
  input  logic               cpuReset,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [NUM_EVT-1:0] evtAck,
  output logic [1:0]         pstate,
  output logic               clkStopEn,
  output logic [NUM_EVT-1:0] evtPend
);

  pstate_t stateQ;
  evtStb_t stb;
  logic    anyPend;

  lpstate_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .stopClkN  (stopClkN),
    .haltReq   (haltReq),
    .snoopStb  (snoopStb),
    .snoopDone (snoopDone),
    .cpuReset  (cpuReset),
    .anyPend   (anyPend),
    .state     (stateQ),
    .stb       (stb),
    .clkStopEn (clkStopEn)
  );

  lpstate_evt #(.NUM_EVT(NUM_EVT), .SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .evtAck  (evtAck),
    .stb     (stb),
    .evtPend (evtPend),
    .anyPend (anyPend)
  );

  assign pstate = stateQ;

endmodule

// File: tb/lpstate_ctrl_tb.sv
`timescale 1ns/1ps
module lpstate_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stopClkN = 1'b1;
  logic       haltReq = 1'b0;
  logic       snoopStb = 1'b0;
  logic       snoopDone = 1'b0;
  logic       cpuReset = 1'b0;
  logic [4:0] evtIn = '0;
  logic [4:0] evtAck = '0;
  logic [1:0] pstate;
  logic       clkStopEn;
  logic [4:0] evtPend;

  int    nChecks = 0;
  int    nFail = 0;
  bit    finished = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  lpstate_ctrl u_dut (
    .clk(clk), .rstN(rstN), .stopClkN(stopClkN), .haltReq(haltReq),
    .snoopStb(snoopStb), .snoopDone(snoopDone), .cpuReset(cpuReset),
    .evtIn(evtIn), .evtAck(evtAck), .pstate(pstate),
    .clkStopEn(clkStopEn), .evtPend(evtPend)
  );

  // Behavioural reference model
  logic       stopQ[$];
  logic [4:0] evQ[$];
  int         mState;
  bit         mRetHalt;
  logic [4:0] mLatch;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopQ = '{1'b1, 1'b1};
      evQ = '{5'd0, 5'd0};
      mState = 0; mRetHalt = 0; mLatch = '0;
    end else begin
      logic sOld;
      logic [4:0] eOld, nLatch;
      bit act, pres;
      int nState;
      bit nRet;
      sOld = stopQ.pop_back(); stopQ.push_front(stopClkN);
      eOld = evQ.pop_back();   evQ.push_front(evtIn);
      act = !sOld;
      pres = (mState == 0 || mState == 1);
      nLatch = cpuReset ? 5'd0 : ((mLatch & ~(pres ? evtAck : 5'd0)) | eOld);
      nState = mState; nRet = mRetHalt;
      if (mState == 0) begin
        if (act) begin nState = 2; nRet = 0; end
        else if (!cpuReset && haltReq) nState = 1;
      end else if (mState == 1) begin
        if (act) begin nState = 2; nRet = !cpuReset; end
        else if (cpuReset || mLatch != 0) nState = 0;
      end else if (mState == 2) begin
        if (cpuReset) nRet = 0;
        if (!act) nState = (mRetHalt && !cpuReset) ? 1 : 0;
        else if (snoopStb) nState = 3;
      end else begin
        if (cpuReset) nRet = 0;
        if (snoopDone) nState = 2;
      end
      mState = nState; mRetHalt = nRet; mLatch = nLatch;
    end
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [4:0] expPend;
      expPend = (mState < 2) ? mLatch : 5'd0;
      chk({curReq, " model pstate"}, pstate, mState);
      chk({curReq, " model clkStopEn"}, clkStopEn, (mState == 2));
      chk({curReq, " model evtPend"}, evtPend, expPend);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R1 reset state", pstate, 0);
    chk("R1 reset clkStopEn", clkStopEn, 0);
    chk("R1 reset evtPend", evtPend, 0);

    curReq = "R5";
    snoopStb = 1; step(1); snoopStb = 0;
    chk("R5 snoop ignored in Normal", pstate, 0);

    curReq = "R2";
    haltReq = 1; step(1); haltReq = 0;
    chk("R2 halt entry", pstate, 1);

    curReq = "R3";
    stopClkN = 0; step(2);
    chk("R3 sync latency not yet", pstate, 1);
    step(1);
    chk("R3 stop-grant from halt", pstate, 2);
    chk("R6 clkStopEn in stop-grant", clkStopEn, 1);

    curReq = "R7";
    evtIn = 5'b00101; step(1); evtIn = 0; step(4);
    chk("R7 events deferred", evtPend, 0);
    curReq = "R8";
    evtAck = 5'b00001; step(1); evtAck = 0;

    curReq = "R5";
    snoopStb = 1; step(1); snoopStb = 0;
    chk("R5 grant-snoop entry", pstate, 3);
    chk("R6 clkStopEn low in snoop", clkStopEn, 0);
    snoopDone = 1; step(1); snoopDone = 0;
    chk("R5 snoop return", pstate, 2);

    curReq = "R4";
    stopClkN = 1; step(3);
    chk("R4 return to halt", pstate, 1);
    chk("R8 ack in stop-grant ignored", evtPend, 5'b00101);
    step(1);
    chk("R9 wake from halt", pstate, 0);
    chk("R7 presented in Normal", evtPend, 5'b00101);

    curReq = "R8";
    evtAck = 5'b00001; step(1); evtAck = 0;
    chk("R8 per-flag ack", evtPend, 5'b00100);
    evtAck = 5'b00100; step(1); evtAck = 0;
    chk("R8 second ack", evtPend, 0);

    evtIn = 5'b01000; step(1); evtIn = 0; step(3);
    chk("R7 latched in Normal", evtPend, 5'b01000);
    evtIn = 5'b01000; step(1); evtIn = 0; step(1);
    evtAck = 5'b01000; step(1); evtAck = 0;
    chk("R8 set wins over ack", evtPend, 5'b01000);
    evtAck = 5'b01000; step(1); evtAck = 0;
    chk("R8 ack after collision", evtPend, 0);

    evtIn = 5'b10010; step(1); evtIn = 0; step(3);
    chk("R8 multiple pending", evtPend, 5'b10010);
    evtAck = 5'b00010; step(1); evtAck = 0;
    chk("R8 one of many acked", evtPend, 5'b10000);
    evtAck = 5'b10000; step(1); evtAck = 0;

    curReq = "R4";
    stopClkN = 0; step(3);
    chk("R3 stop-grant from Normal", pstate, 2);
    stopClkN = 1; step(3);
    chk("R4 return to Normal", pstate, 0);

    curReq = "R10";
    haltReq = 1; step(1); haltReq = 0;
    stopClkN = 0; step(3);
    evtIn = 5'b00001; step(1); evtIn = 0; step(3);
    cpuReset = 1; step(1); cpuReset = 0;
    chk("R10 reset keeps stop-grant", pstate, 2);
    stopClkN = 1; step(3);
    chk("R10 wake target Normal", pstate, 0);
    chk("R10 events cleared", evtPend, 0);

    haltReq = 1; step(1); haltReq = 0;
    chk("R2 halt again", pstate, 1);
    cpuReset = 1; step(1); cpuReset = 0;
    chk("R10 reset in halt", pstate, 0);

    step(4);
    summary();
  end

endmodule